// File: doc/BRIEF.md
# Operand-Wakeup Issue Buffer

This block holds instructions that are waiting for their source operands in an out-of-order core. Each slot keeps one instruction record: two source register tags, a destination tag, a reorder-buffer id, an operation type with its two function fields, two operand values, an immediate and a program counter. Filling a slot takes two steps. A dispatch stage first reserves a free slot, and the block hands back its index. The stage later writes the record into that slot.

When a functional unit finishes, it broadcasts the tag and value of the register it produced. Every occupied slot waiting on that tag captures the value and marks that operand as available by zeroing the tag. A slot with both tags at zero is ready to issue. The ready slots are reported as one bitmask per operation-type group. An issue stage picks a slot from its mask and takes it, which reads the record out and frees the slot.

Every operation completes in one clock edge. Reserve, fill, wakeup and take may all occur in the same cycle.

Top module: `wakeup_station`

## Requirements
- R1: After reset every slot is unreserved and empty. `sel_ready` is 1, `sel_idx` is 0, and every bit of `grp_mask` and `grp_ready` is 0.
- R2: `sel_idx` shows the lowest-numbered slot that is not reserved, and `sel_ready` shows whether such a slot exists. A cycle with `sel_valid` and `sel_ready` both high reserves that slot from the next cycle. `sel_ready` is 0 once all slots are reserved.
- R3: A take (`take_valid` with `take_idx`) clears the slot's reserved and occupied status at the next edge, and the slot leaves every ready mask. Take acts before select in the same cycle, so a slot freed by a take is visible to `sel_idx` and `sel_ready` in that same cycle.
- R4: A fill (`ins_valid`, `ins_idx`, `ins_rec`) writes the record into the slot and marks it occupied at the next edge, whether or not the slot was reserved. The record layout of `ins_rec` and `take_rec`, from the most significant bit down, is:
  - src1 tag [92:89]
  - src2 tag [88:85]
  - dst tag [84:81]
  - rob id [80:77]
  - op type [76:74]
  - funct3 [73:71]
  - funct7 [70:64]
  - operand 1 value [63:48]
  - operand 2 value [47:32]
  - imm [31:16]
  - pc [15:0]
- R5: A wakeup (`upd_valid`, `upd_tag`, `upd_val`) with a nonzero tag works on every occupied slot. In each such slot, a src1 tag equal to `upd_tag` becomes 0 and operand 1 becomes `upd_val`. src2 and operand 2 are handled the same way, independently, in the same edge. One wakeup can free both operands of a slot and operands in several slots.
- R6: A wakeup with tag 0 has no effect on any slot.
- R7: If a fill and a matching wakeup happen in the same cycle, the record is stored with the wakeup already applied.
- R8: A slot is ready when it is occupied and both of its source tags are 0. Bit i of group g's mask (`grp_mask[g*ENTRIES+i]`) is set when slot i is ready and its op type belongs to group g. Group membership is bit `op` of `GROUP_TYPES[g*8 +: 8]`. By default group 0 holds types 1 and 2, and group 1 holds types 3 and 4.
- R9: `grp_ready[g]` is 1 exactly when group g's mask is nonzero.
- R10: `take_rec` shows, in the same cycle, the stored record of slot `take_idx`, including any values that earlier wakeups wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Request to reserve a slot |
| sel_ready | output | 1 | An unreserved slot exists |
| sel_idx | output | IDX_W | Slot that a reservation would take |
| ins_valid | input | 1 | Fill request |
| ins_idx | input | IDX_W | Slot to fill |
| ins_rec | input | 93 | Record to store |
| upd_valid | input | 1 | Wakeup broadcast valid |
| upd_tag | input | 4 | Produced register tag |
| upd_val | input | 16 | Produced register value |
| take_valid | input | 1 | Take request |
| take_idx | input | IDX_W | Slot to read and free |
| take_rec | output | 93 | Record held in slot `take_idx` |
| grp_mask | output | GROUPS*ENTRIES | Per-group ready masks |
| grp_ready | output | GROUPS | Per-group mask is nonzero |

## Verification
`sel_idx`, `sel_ready` and `take_rec` are combinational. They are checked in the same cycle as the stimulus, one nanosecond after the inputs settle. Reserve, fill, wakeup and take change the stored state at the next rising edge. The ready masks depend only on that state, so every mask check is made one nanosecond after the edge that follows the stimulus. A reference model in the bench tracks the tags and values of each slot, and the wakeup sweep compares both group masks against it after each broadcast tag.

// File: rtl/ws_pkg.sv
package ws_pkg;
    localparam int TAG_W  = 4;
    localparam int ROB_W  = 4;
    localparam int OP_W   = 3;
    localparam int F3_W   = 3;
    localparam int F7_W   = 7;
    localparam int DATA_W = 16;
    localparam int NTYPES = 1 << OP_W;

    typedef struct packed {
        logic [TAG_W-1:0]  src1;
        logic [TAG_W-1:0]  src2;
        logic [TAG_W-1:0]  dst;
        logic [ROB_W-1:0]  rob;
        logic [OP_W-1:0]   op;
        logic [F3_W-1:0]   f3;
        logic [F7_W-1:0]   f7;
        logic [DATA_W-1:0] val1;
        logic [DATA_W-1:0] val2;
        logic [DATA_W-1:0] imm;
        logic [DATA_W-1:0] pc;
    } rec_t;

    localparam int REC_W = $bits(rec_t);

    typedef struct packed {
        logic reserved;
        logic full;
        rec_t rec;
    } slot_t;
endpackage

// File: rtl/ws_lowfree.sv
module ws_lowfree #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     free_vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (found) begin
            assert (free_vec[idx]);
        end
    end
endmodule

// File: rtl/ws_slot.sv
module ws_slot
    import ws_pkg::*;
(
    input  slot_t             slot_q,
    input  logic              take_hit,
    input  logic              sel_hit,
    input  logic              ins_hit,
    input  rec_t              ins_rec,
    input  logic              upd_valid,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [DATA_W-1:0] upd_val,
    output slot_t             slot_d,
    output logic              ready
);
    // Order inside one edge: take, then reserve, then fill, then wakeup.
    always_comb begin
        slot_d = slot_q;
        if (take_hit) begin
            slot_d.reserved = 1'b0;
            slot_d.full     = 1'b0;
        end
        if (sel_hit) begin
            slot_d.reserved = 1'b1;
        end
        if (ins_hit) begin
            slot_d.full = 1'b1;
            slot_d.rec  = ins_rec;
        end
        if (upd_valid && (upd_tag != '0) && slot_d.full) begin
            if (slot_d.rec.src1 == upd_tag) begin
                slot_d.rec.src1 = '0;
                slot_d.rec.val1 = upd_val;
            end
            if (slot_d.rec.src2 == upd_tag) begin
                slot_d.rec.src2 = '0;
                slot_d.rec.val2 = upd_val;
            end
        end
    end

    assign ready = slot_q.full && (slot_q.rec.src1 == '0) && (slot_q.rec.src2 == '0);
endmodule

// File: rtl/ws_group_mask.sv
module ws_group_mask #(
    parameter int                N        = 4,
    parameter int                OPW      = 3,
    parameter logic [(1<<OPW)-1:0] TYPE_SET = '1
) (
    input  logic [N-1:0]     rdy_vec,
    input  logic [N*OPW-1:0] ops_flat,
    output logic [N-1:0]     mask,
    output logic             any
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            mask[i] = rdy_vec[i] && TYPE_SET[ops_flat[i*OPW +: OPW]];
        end
    end

    assign any = |mask;
endmodule

// File: rtl/wakeup_station.sv
module wakeup_station
    import ws_pkg::*;
#(
    parameter int                          ENTRIES     = 4,
    parameter int                          GROUPS      = 2,
    parameter logic [GROUPS*NTYPES-1:0]    GROUP_TYPES = 16'h1806,
    localparam int                         IDX_W       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_valid,
    output logic                      sel_ready,
    output logic [IDX_W-1:0]          sel_idx,
    input  logic                      ins_valid,
    input  logic [IDX_W-1:0]          ins_idx,
    input  logic [REC_W-1:0]          ins_rec,
    input  logic                      upd_valid,
    input  logic [TAG_W-1:0]          upd_tag,
    input  logic [DATA_W-1:0]         upd_val,
    input  logic                      take_valid,
    input  logic [IDX_W-1:0]          take_idx,
    output logic [REC_W-1:0]          take_rec,
    output logic [GROUPS*ENTRIES-1:0] grp_mask,
    output logic [GROUPS-1:0]         grp_ready
);
    typedef struct packed {
        slot_t [ENTRIES-1:0] slots;
    } state_t;

    state_t state_d, state_q;

    logic [ENTRIES-1:0]      take_hit, sel_hit, ins_hit, free_vec, rdy_vec;
    logic [ENTRIES-1:0]      full_vec, resv_vec;
    logic [ENTRIES*OP_W-1:0] ops_flat;
    logic                    sel_fire;
    rec_t                    ins_rec_s;

    assign ins_rec_s = rec_t'(ins_rec);

    // Per-slot decode; a take frees its slot before the allocator looks.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            take_hit[i] = take_valid && (take_idx == IDX_W'(i));
            ins_hit[i]  = ins_valid && (ins_idx == IDX_W'(i));
            free_vec[i] = !state_q.slots[i].reserved || take_hit[i];
            full_vec[i] = state_q.slots[i].full;
            resv_vec[i] = state_q.slots[i].reserved;
            ops_flat[i*OP_W +: OP_W] = state_q.slots[i].rec.op;
        end
    end

    ws_lowfree #(.N(ENTRIES), .IDX_W(IDX_W)) u_lowfree (
        .free_vec (free_vec),
        .found    (sel_ready),
        .idx      (sel_idx)
    );

    assign sel_fire = sel_valid && sel_ready;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            sel_hit[i] = sel_fire && (sel_idx == IDX_W'(i));
        end
    end

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
            ws_slot u_slot (
                .slot_q    (state_q.slots[e]),
                .take_hit  (take_hit[e]),
                .sel_hit   (sel_hit[e]),
                .ins_hit   (ins_hit[e]),
                .ins_rec   (ins_rec_s),
                .upd_valid (upd_valid),
                .upd_tag   (upd_tag),
                .upd_val   (upd_val),
                .slot_d    (state_d.slots[e]),
                .ready     (rdy_vec[e])
            );

            // Wakeup of a settled, untouched slot.
            assert_wake_src1_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && upd_tag != '0 && state_q.slots[e].full
                 && state_q.slots[e].rec.src1 == upd_tag && !take_hit[e] && !ins_hit[e])
                |=> (state_q.slots[e].rec.src1 == '0 && state_q.slots[e].rec.val1 == $past(upd_val)));

            assert_wake_src2_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && upd_tag != '0 && state_q.slots[e].full
                 && state_q.slots[e].rec.src2 == upd_tag && !take_hit[e] && !ins_hit[e])
                |=> (state_q.slots[e].rec.src2 == '0 && state_q.slots[e].rec.val2 == $past(upd_val)));

            // Fill and matching wakeup in the same cycle.
            assert_fill_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (ins_hit[e] && upd_valid && upd_tag != '0 && ins_rec_s.src1 == upd_tag)
                |=> (state_q.slots[e].rec.src1 == '0 && state_q.slots[e].rec.val1 == $past(upd_val)));

            // Wakeup with tag 0 leaves an untouched slot unchanged.
            assert_zero_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && upd_tag == '0 && !take_hit[e] && !ins_hit[e] && !sel_hit[e])
                |=> $stable(state_q.slots[e]));
        end

        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            ws_group_mask #(
                .N        (ENTRIES),
                .OPW      (OP_W),
                .TYPE_SET (GROUP_TYPES[g*NTYPES +: NTYPES])
            ) u_mask (
                .rdy_vec  (rdy_vec),
                .ops_flat (ops_flat),
                .mask     (grp_mask[g*ENTRIES +: ENTRIES]),
                .any      (grp_ready[g])
            );

            assert_grp_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
                grp_ready[g] |-> (rdy_vec != '0));
        end
    endgenerate

    assign take_rec = state_q.slots[take_idx].rec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assert_sel_reserves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fire |=> resv_vec[$past(sel_idx)]);

    assert_sel_exhausted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_valid && !sel_ready) |-> (resv_vec == '1));

    assert_take_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && !(ins_valid && ins_idx == take_idx))
        |=> !full_vec[$past(take_idx)]);

    assert_fill_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> full_vec[$past(ins_idx)]);

    assert_ready_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_vec[0]) |-> full_vec[0]);
endmodule

// File: tb/wakeup_station_bench.sv
module wakeup_station_bench;
    import ws_pkg::*;

    localparam int E = 4;
    localparam int G = 2;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_valid = 1'b0, ins_valid = 1'b0, upd_valid = 1'b0, take_valid = 1'b0;
    logic sel_ready;
    logic [IW-1:0] sel_idx;
    logic [IW-1:0] ins_idx = '0, take_idx = '0;
    logic [REC_W-1:0] ins_rec = '0;
    logic [REC_W-1:0] take_rec;
    logic [TAG_W-1:0] upd_tag = '0;
    logic [DATA_W-1:0] upd_val = '0;
    logic [G*E-1:0] grp_mask;
    logic [G-1:0] grp_ready;

    int n_chk = 0;
    int n_err = 0;

    rec_t m_rec [E];
    logic m_full [E];

    always #2 clk = ~clk;

    wakeup_station u_wakeup_station (
        .clk(clk), .rst_n(rst_n),
        .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_idx(sel_idx),
        .ins_valid(ins_valid), .ins_idx(ins_idx), .ins_rec(ins_rec),
        .upd_valid(upd_valid), .upd_tag(upd_tag), .upd_val(upd_val),
        .take_valid(take_valid), .take_idx(take_idx), .take_rec(take_rec),
        .grp_mask(grp_mask), .grp_ready(grp_ready)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic rec_t mk(input int i);
        rec_t r;
        r.src1 = TAG_W'(i + 1);
        r.src2 = TAG_W'(4 - i);
        r.dst  = TAG_W'(8 + i);
        r.rob  = ROB_W'(i * 3);
        r.op   = OP_W'(i + 1);
        r.f3   = F3_W'(2);
        r.f7   = F7_W'(4);
        r.val1 = DATA_W'(16'h0100 + i);
        r.val2 = DATA_W'(16'h0200 + i);
        r.imm  = DATA_W'(16'h0300 + i);
        r.pc   = DATA_W'(16'h0400 + 4 * i);
        return r;
    endfunction

    function automatic void model_wake(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v);
        if (t == 0) return;
        for (int i = 0; i < E; i++) begin
            if (m_full[i] && m_rec[i].src1 == t) begin m_rec[i].src1 = 0; m_rec[i].val1 = v; end
            if (m_full[i] && m_rec[i].src2 == t) begin m_rec[i].src2 = 0; m_rec[i].val2 = v; end
        end
    endfunction

    // Group 0 holds types 1 and 2, group 1 holds types 3 and 4.
    function automatic logic [E-1:0] exp_mask(input int g);
        logic [E-1:0] m = '0;
        for (int i = 0; i < E; i++) begin
            logic in_g;
            in_g = (g == 0) ? (m_rec[i].op == 1 || m_rec[i].op == 2)
                            : (m_rec[i].op == 3 || m_rec[i].op == 4);
            m[i] = m_full[i] && m_rec[i].src1 == 0 && m_rec[i].src2 == 0 && in_g;
        end
        return m;
    endfunction

    task automatic chk_masks(input string req);
        for (int g = 0; g < G; g++) begin
            chk(req, 128'(grp_mask[g*E +: E]), 128'(exp_mask(g)));
            chk("R9 group ready", 128'(grp_ready[g]), 128'(exp_mask(g) != 0));
        end
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < E; i++) begin m_full[i] = 0; m_rec[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 sel_ready", 128'(sel_ready), 128'(1));
        chk("R1 sel_idx", 128'(sel_idx), 128'(0));
        chk("R1 grp_mask", 128'(grp_mask), 128'(0));
        chk("R1 grp_ready", 128'(grp_ready), 128'(0));

        // R2 reservation sweep
        for (int k = 0; k < E; k++) begin
            sel_valid = 1'b1;
            #1;
            chk("R2 sel_ready", 128'(sel_ready), 128'(1));
            chk("R2 sel_idx lowest", 128'(sel_idx), 128'(k));
            tick();
        end
        sel_valid = 1'b0;
        #1 chk("R2 exhausted", 128'(sel_ready), 128'(0));

        // R3 take before select in one cycle
        take_valid = 1'b1; take_idx = 0; sel_valid = 1'b1;
        #1;
        chk("R3 freed visible", 128'(sel_ready), 128'(1));
        chk("R3 freed idx", 128'(sel_idx), 128'(0));
        tick();
        take_valid = 1'b0; sel_valid = 1'b0;
        #1 chk("R2 re-reserved", 128'(sel_ready), 128'(0));

        // R4 fill every slot, read back
        for (int i = 0; i < E; i++) begin
            ins_valid = 1'b1; ins_idx = IW'(i); ins_rec = mk(i);
            tick();
            m_full[i] = 1; m_rec[i] = mk(i);
        end
        ins_valid = 1'b0;
        for (int i = 0; i < E; i++) begin
            take_idx = IW'(i);
            #1 chk("R4 stored record", 128'(take_rec), 128'(m_rec[i]));
        end
        chk_masks("R8 none ready");

        // R5/R8 wakeup sweep over tags
        for (int t = 1; t <= 4; t++) begin
            upd_valid = 1'b1; upd_tag = TAG_W'(t); upd_val = DATA_W'(16'h1000 + 17 * t);
            tick();
            upd_valid = 1'b0;
            model_wake(TAG_W'(t), DATA_W'(16'h1000 + 17 * t));
            chk_masks("R5 R8 wake mask");
        end

        // R10 take read-out and R3 mask removal
        for (int i = 0; i < E; i++) begin
            take_valid = 1'b1; take_idx = IW'(i);
            #1 chk("R10 take record", 128'(take_rec), 128'(m_rec[i]));
            tick();
            take_valid = 1'b0;
            m_full[i] = 0;
            #1 chk_masks("R3 take clears mask");
        end

        // R6 wakeup with tag 0 ignored
        begin
            rec_t r;
            r = mk(0); r.src1 = 0; r.src2 = 0; r.val1 = 16'h1111;
            ins_valid = 1'b1; ins_idx = 0; ins_rec = r;
            tick();
            ins_valid = 1'b0; m_full[0] = 1; m_rec[0] = r;
            upd_valid = 1'b1; upd_tag = 0; upd_val = 16'h2222;
            tick();
            upd_valid = 1'b0;
            take_idx = 0;
            #1 chk("R6 zero tag ignored", 128'(take_rec), 128'(m_rec[0]));
            chk_masks("R6 R8 mask");
        end

        // R7 fill and matching wakeup in one cycle
        begin
            rec_t r;
            r = mk(2); r.src1 = 6; r.src2 = 6;
            ins_valid = 1'b1; ins_idx = 1; ins_rec = r;
            upd_valid = 1'b1; upd_tag = 6; upd_val = 16'hBEEF;
            tick();
            ins_valid = 1'b0; upd_valid = 1'b0;
            m_full[1] = 1; m_rec[1] = r;
            model_wake(6, 16'hBEEF);
            take_idx = 1;
            #1 chk("R7 bypass record", 128'(take_rec), 128'(m_rec[1]));
            chk_masks("R7 R8 mask");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule